// File: doc/BRIEF.md
# Modem Control Path with Local Loopback

This block sits between a UART core and the modem and serial pins. It holds one control byte. Four of its bits request the data-terminal-ready, request-to-send and two general-purpose outputs. One bit turns on a local diagnostic loop, and one bit turns on automatic flow control. The block drives the active-low modem output pins from these bits. It also chooses which signals the core sees: the external modem inputs and serial input, or internally looped copies of its own outputs.

When the loop is on, the external serial input and the four external modem inputs are ignored. The transmit shift-register bit goes straight to the receiver, and the serial output pin stays at idle high. Every modem output pin is parked high, which is inactive. Each control bit reappears at one modem input of the core: RTS at CTS, DTR at DSR, OUT1 at RI and OUT2 at DCD. This lets software test the whole character path and the modem-status path without any external wiring.

The automatic flow enable selects between two modes. With RTS also set, both automatic CTS and automatic RTS are active. With RTS clear, only automatic CTS is active. Under automatic CTS, the transmitter may start a new character only while CTS is asserted. Under automatic RTS, the core's receive-hold request de-asserts the RTS pin.

Top module: `mdm_loop_ctl`

## Requirements
- R1: After synchronous reset the control byte reads 0x00, every modem output pin and the serial output pin are high, and the loop is off.
- R2: A write stores data bits 5:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loop, bit 5 autoflow). The new value appears on `ctl_q` after the clock edge of the write, and bits 7:6 always read 0.
- R3: With the loop off, each of control bits 0..3 that is set drives its pin low, and each that is clear drives its pin high (DTR→`dtr_n_pin`, RTS→`rts_n_pin`, OUT1→`out1_n_pin`, OUT2→`out2_n_pin`).
- R4: With the loop off, `sout_pin` follows `tsr_bit` and `rx_serial` follows `sin_pin`. With the loop on, `sout_pin` is 1, `rx_serial` follows `tsr_bit`, and `sin_pin` has no effect.
- R5: With the loop on, all four modem output pins are 1, whatever the control bits are.
- R6: With the loop on, the core-side inputs show the register bits: `cts`=RTS, `dsr`=DTR, `ri`=OUT1, `dcd`=OUT2. The external modem input pins have no effect.
- R7: With the loop off, each core-side input is the inverse of its active-low pin (`cts`=!`cts_n_pin`, `dsr`=!`dsr_n_pin`, `dcd`=!`dcd_n_pin`, `ri`=!`ri_n_pin`).
- R8: Autoflow bit set with RTS set gives `auto_cts_en`=1 and `auto_rts_en`=1. Autoflow set with RTS clear gives `auto_cts_en`=1 and `auto_rts_en`=0. Autoflow clear gives 0 for both.
- R9: `tx_start_ok` equals the core-side `cts` while automatic CTS is active, and is 1 otherwise.
- R10: With the loop off and automatic RTS active, `rx_hold`=1 drives `rts_n_pin` high. With `rx_hold`=0 the pin follows R3. Outside automatic RTS, `rx_hold` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte write data |
| ctl_q | output | 8 | Current control byte, reserved bits zero |
| sin_pin | input | 1 | External serial input |
| tsr_bit | input | 1 | Transmit shift-register output from the core |
| rx_serial | output | 1 | Serial bit presented to the receiver |
| sout_pin | output | 1 | Serial output pin |
| cts_n_pin | input | 1 | External clear-to-send, active low |
| dsr_n_pin | input | 1 | External data-set-ready, active low |
| dcd_n_pin | input | 1 | External carrier-detect, active low |
| ri_n_pin | input | 1 | External ring indicator, active low |
| dtr_n_pin | output | 1 | Data-terminal-ready pin, active low |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| out1_n_pin | output | 1 | General output 1 pin, active low |
| out2_n_pin | output | 1 | General output 2 pin, active low |
| cts | output | 1 | Core-side clear-to-send, active high |
| dsr | output | 1 | Core-side data-set-ready, active high |
| dcd | output | 1 | Core-side carrier-detect, active high |
| ri | output | 1 | Core-side ring indicator, active high |
| rx_hold | input | 1 | Core receive path requests the sender to pause |
| auto_cts_en | output | 1 | Automatic CTS gating active |
| auto_rts_en | output | 1 | Automatic RTS control active |
| tx_start_ok | output | 1 | Transmitter may begin a new character |

## Verification
The assertions assume that every input is at a known 0 or 1 level at each rising clock edge. They also assume that a write is presented as one strobe with its data held stable around that edge. The stimulus keeps within this by changing inputs only away from the rising edge. It raises the write strobe for exactly one clock per control value. After each write it holds the strobe low, so the control byte stays fixed while every combination of the serial inputs, modem pins and receive-hold input is applied.

// File: rtl/mdm_loop_pkg.sv
package mdm_loop_pkg;

    localparam int REG_W    = 8;
    localparam int CTL_N    = 4;
    localparam int IDX_DTR  = 0;
    localparam int IDX_RTS  = 1;
    localparam int IDX_OUT1 = 2;
    localparam int IDX_OUT2 = 3;
    localparam int IDX_LOOP = CTL_N;
    localparam int IDX_AFE  = CTL_N + 1;
    localparam int USED_W   = IDX_AFE + 1;
    localparam int RSV_W    = REG_W - USED_W;

    typedef struct packed {
        logic             afe;
        logic             loop;
        logic [CTL_N-1:0] ctl;
    } mdm_cfg_t;

    typedef enum logic [1:0] {
        FLOW_OFF      = 2'd0,
        FLOW_CTS_ONLY = 2'd1,
        FLOW_CTS_RTS  = 2'd2
    } flow_mode_e;

    function automatic mdm_cfg_t cfg_from_bits(input logic [USED_W-1:0] b);
        mdm_cfg_t c;
        c.ctl  = b[CTL_N-1:0];
        c.loop = b[IDX_LOOP];
        c.afe  = b[IDX_AFE];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_byte(input mdm_cfg_t c);
        return {{RSV_W{1'b0}}, c.afe, c.loop, c.ctl};
    endfunction

    function automatic flow_mode_e flow_of(input mdm_cfg_t c);
        if (!c.afe)            return FLOW_OFF;
        else if (c.ctl[IDX_RTS]) return FLOW_CTS_RTS;
        else                   return FLOW_CTS_ONLY;
    endfunction

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output mdm_cfg_t         cfg,
    output logic [REG_W-1:0] ctl_q
);

    mdm_cfg_t cfg_r;
    logic     rst_seen;
    logic     unused_rsv;

    assign unused_rsv = ^wr_data[REG_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= '0;
        end else if (wr_en) begin
            cfg_r <= cfg_from_bits(wr_data[USED_W-1:0]);
        end
    end

    assign cfg   = cfg_r;
    assign ctl_q = cfg_to_byte(cfg_r);

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            assert_reset_zero_R1: assert (ctl_q == '0)
                else $error("control byte not cleared by reset");
        end
    end

    assert_write_store_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctl_q[USED_W-1:0] == $past(wr_data[USED_W-1:0])))
        else $error("write data not stored");

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_q[REG_W-1:USED_W] == '0)
        else $error("reserved bits not zero");

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl_q))
        else $error("control byte changed without write");

endmodule

// File: rtl/mdm_flow.sv
module mdm_flow
    import mdm_loop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mdm_cfg_t cfg,
    input  logic     cts_core,
    input  logic     rx_hold,
    output logic     auto_cts_en,
    output logic     auto_rts_en,
    output logic     rts_drive,
    output logic     tx_start_ok
);

    flow_mode_e mode;

    always_comb begin
        mode        = flow_of(cfg);
        auto_cts_en = 1'b0;
        auto_rts_en = 1'b0;
        unique case (mode)
            FLOW_CTS_RTS: begin
                auto_cts_en = 1'b1;
                auto_rts_en = 1'b1;
            end
            FLOW_CTS_ONLY: auto_cts_en = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        rts_drive   = cfg.ctl[IDX_RTS] && !(auto_rts_en && rx_hold);
        tx_start_ok = auto_cts_en ? cts_core : 1'b1;
    end

    assert_mode_nest_R8: assert property (@(posedge clk) disable iff (rst)
        auto_rts_en |-> (auto_cts_en && cfg.ctl[IDX_RTS]))
        else $error("automatic RTS without automatic CTS");

    assert_tx_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (auto_cts_en && !cts_core) |-> !tx_start_ok)
        else $error("transmit allowed while CTS low");

    assert_hold_rts_R10: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && rx_hold) |-> !rts_drive)
        else $error("RTS asserted during receive hold");

endmodule

// File: rtl/mdm_pin_mux.sv
module mdm_pin_mux
    import mdm_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mdm_cfg_t         cfg,
    input  logic [CTL_N-1:0] drive,
    input  logic [CTL_N-1:0] pin_in_n,
    input  logic             sin_pin,
    input  logic             tsr_bit,
    output logic [CTL_N-1:0] pin_out_n,
    output logic [CTL_N-1:0] core_in,
    output logic             sout_pin,
    output logic             rx_serial
);

    for (genvar k = 0; k < CTL_N; k++) begin : g_line
        always_comb begin
            pin_out_n[k] = cfg.loop ? 1'b1 : !drive[k];
            core_in[k]   = cfg.loop ? cfg.ctl[k] : !pin_in_n[k];
        end
    end

    always_comb begin
        sout_pin  = cfg.loop ? 1'b1    : tsr_bit;
        rx_serial = cfg.loop ? tsr_bit : sin_pin;
    end

    assert_loop_park_R5: assert property (@(posedge clk) disable iff (rst)
        cfg.loop |-> (&pin_out_n && sout_pin))
        else $error("outputs not parked in loop");

    assert_loop_map_R6: assert property (@(posedge clk) disable iff (rst)
        cfg.loop |-> (core_in == cfg.ctl))
        else $error("looped inputs differ from control bits");

    assert_rx_src_R4: assert property (@(posedge clk) disable iff (rst)
        cfg.loop |-> (rx_serial == tsr_bit))
        else $error("receiver not fed from shift register in loop");

    assert_ext_in_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg.loop |-> ((core_in ^ pin_in_n) == {CTL_N{1'b1}}))
        else $error("external modem inputs not inverted through");

endmodule

// File: rtl/mdm_loop_ctl.sv
module mdm_loop_ctl
    import mdm_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctl_q,
    input  logic             sin_pin,
    input  logic             tsr_bit,
    output logic             rx_serial,
    output logic             sout_pin,
    input  logic             cts_n_pin,
    input  logic             dsr_n_pin,
    input  logic             dcd_n_pin,
    input  logic             ri_n_pin,
    output logic             dtr_n_pin,
    output logic             rts_n_pin,
    output logic             out1_n_pin,
    output logic             out2_n_pin,
    output logic             cts,
    output logic             dsr,
    output logic             dcd,
    output logic             ri,
    input  logic             rx_hold,
    output logic             auto_cts_en,
    output logic             auto_rts_en,
    output logic             tx_start_ok
);

    mdm_cfg_t         cfg;
    logic [CTL_N-1:0] drive;
    logic [CTL_N-1:0] pin_in_n;
    logic [CTL_N-1:0] pin_out_n;
    logic [CTL_N-1:0] core_in;
    logic             rts_drive;

    mdm_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .ctl_q   (ctl_q)
    );

    mdm_flow u_flow (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .cts_core    (core_in[IDX_RTS]),
        .rx_hold     (rx_hold),
        .auto_cts_en (auto_cts_en),
        .auto_rts_en (auto_rts_en),
        .rts_drive   (rts_drive),
        .tx_start_ok (tx_start_ok)
    );

    always_comb begin
        drive           = cfg.ctl;
        drive[IDX_RTS]  = rts_drive;
        pin_in_n[IDX_DTR]  = dsr_n_pin;
        pin_in_n[IDX_RTS]  = cts_n_pin;
        pin_in_n[IDX_OUT1] = ri_n_pin;
        pin_in_n[IDX_OUT2] = dcd_n_pin;
    end

    mdm_pin_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .drive     (drive),
        .pin_in_n  (pin_in_n),
        .sin_pin   (sin_pin),
        .tsr_bit   (tsr_bit),
        .pin_out_n (pin_out_n),
        .core_in   (core_in),
        .sout_pin  (sout_pin),
        .rx_serial (rx_serial)
    );

    assign dtr_n_pin  = pin_out_n[IDX_DTR];
    assign rts_n_pin  = pin_out_n[IDX_RTS];
    assign out1_n_pin = pin_out_n[IDX_OUT1];
    assign out2_n_pin = pin_out_n[IDX_OUT2];
    assign dsr        = core_in[IDX_DTR];
    assign cts        = core_in[IDX_RTS];
    assign ri         = core_in[IDX_OUT1];
    assign dcd        = core_in[IDX_OUT2];

endmodule

// File: tb/mdm_loop_ctl_tb.sv
module mdm_loop_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctl_q;
    logic       sin_pin = 1'b1, tsr_bit = 1'b1;
    logic       rx_serial, sout_pin;
    logic       cts_n_pin = 1'b1, dsr_n_pin = 1'b1, dcd_n_pin = 1'b1, ri_n_pin = 1'b1;
    logic       dtr_n_pin, rts_n_pin, out1_n_pin, out2_n_pin;
    logic       cts, dsr, dcd, ri;
    logic       rx_hold = 1'b0;
    logic       auto_cts_en, auto_rts_en, tx_start_ok;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mdm_loop_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctl_q(ctl_q),
        .sin_pin(sin_pin), .tsr_bit(tsr_bit), .rx_serial(rx_serial), .sout_pin(sout_pin),
        .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin), .dcd_n_pin(dcd_n_pin), .ri_n_pin(ri_n_pin),
        .dtr_n_pin(dtr_n_pin), .rts_n_pin(rts_n_pin), .out1_n_pin(out1_n_pin), .out2_n_pin(out2_n_pin),
        .cts(cts), .dsr(dsr), .dcd(dcd), .ri(ri), .rx_hold(rx_hold),
        .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en), .tx_start_ok(tx_start_ok)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 ctl_q", ctl_q, 8'h00);
        check("R1 pins", {3'b0, sout_pin, dtr_n_pin, rts_n_pin, out1_n_pin, out2_n_pin}, 8'h1F);

        for (int v = 0; v < 64; v++) begin
            logic loop_e, afe_e, auto_rts_e, cts_e, dsr_e, dcd_e, ri_e;
            logic [3:0] pins_e;
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = 8'(v) | ((v % 2 == 1) ? 8'hC0 : 8'h00);
            @(negedge clk);
            wr_en   = 1'b0;
            wr_data = 8'hFF;
            // R2: stored low six bits, reserved zero
            check("R2 ctl_q", ctl_q, 8'(v));
            loop_e     = v[4];
            afe_e      = v[5];
            auto_rts_e = afe_e && v[1];
            for (int p = 0; p < 128; p++) begin
                {rx_hold, tsr_bit, sin_pin, ri_n_pin, dcd_n_pin, dsr_n_pin, cts_n_pin} = 7'(p);
                #1;
                cts_e = loop_e ? v[1] : !cts_n_pin;
                dsr_e = loop_e ? v[0] : !dsr_n_pin;
                ri_e  = loop_e ? v[2] : !ri_n_pin;
                dcd_e = loop_e ? v[3] : !dcd_n_pin;
                pins_e[3] = loop_e ? 1'b1 : !v[0];
                pins_e[2] = loop_e ? 1'b1 : !(v[1] && !(auto_rts_e && rx_hold));
                pins_e[1] = loop_e ? 1'b1 : !v[2];
                pins_e[0] = loop_e ? 1'b1 : !v[3];
                check("R4 serial", {6'b0, sout_pin, rx_serial},
                      {6'b0, (loop_e ? 1'b1 : tsr_bit), (loop_e ? tsr_bit : sin_pin)});
                check(loop_e ? "R5 pins" : (auto_rts_e ? "R10 pins" : "R3 pins"),
                      {4'b0, dtr_n_pin, rts_n_pin, out1_n_pin, out2_n_pin}, {4'b0, pins_e});
                check(loop_e ? "R6 core inputs" : "R7 core inputs",
                      {4'b0, cts, dsr, ri, dcd}, {4'b0, cts_e, dsr_e, ri_e, dcd_e});
                check("R8 flow mode", {6'b0, auto_cts_en, auto_rts_en}, {6'b0, afe_e, auto_rts_e});
                check("R9 tx gate", {7'b0, tx_start_ok}, {7'b0, (afe_e ? cts_e : 1'b1)});
                #1;
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 ctl_q after reset", ctl_q, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule